// File: doc/BRIEF.md
# Indirect Register Reconfiguration Streamer

This block lets a host reconfigure one transceiver channel by replaying a stored configuration image. The host sees a small bank of 32-bit registers at fixed word offsets: a channel select, a control/status word, an internal offset and an internal data word. The host never writes the streamer's internal registers directly. It stages an offset and a data value, then sets a write bit in the control/status word to commit the pair to the internal register that the offset selects.

Internal register 0 holds the ROM base address of the image. Committing the key value 3 to internal register 1 launches playback. The block then reads 32-bit records from a configuration ROM, one at a time, starting at the base. Each record carries a 16-bit target address and a 16-bit data value, and the block issues it as a single handshaked write on the reconfiguration port of the selected channel. A record whose address is all ones ends the image. A busy flag stays up for the whole run, and the host polls it to learn when the image has been applied.

Top module: `rcfg_streamer`

## Requirements
- R1: After reset every host register reads 0, busy is 0, and neither rom_rd nor ch_wr is asserted.
- R2: Host writes at word offset 0x38 (channel, low CH_W bits), 0x3B (offset, 32 bits) and 0x3C (data, 32 bits) read back at the same offsets. The mode field is written and read at bits [3:2] of 0x3A. Any other offset reads 0.
- R3: Bit 0 of 0x3A is the write bit. It always reads 0. Writing it as 1 commits the staged pair, using the mode value carried in that same write. A commit with offset 0 and mode 2'b00 loads the low ROM_AW bits of the data word as the image base address.
- R4: A commit with mode 2'b00, offset 1 and data 0x3 starts streaming. Busy (bit 8 of 0x3A) reads 1 from the cycle after that write.
- R5: Records are read from consecutive ROM addresses from the base upward, wrapping modulo 2^ROM_AW. Each record is read with one rom_rd pulse, and its data arrives one cycle later. Record bits [31:16] are the target address and bits [15:0] are the data.
- R6: Each non-end record produces exactly one channel write: ch_wr is held with stable ch_addr and ch_data until ch_ready is sampled high, no two writes overlap, and ch_sel equals the channel register.
- R7: A record with address 0xFFFF is not written. It ends the stream, and busy clears on the following cycle.
- R8: While busy is 1, host writes to 0x38, 0x3B, 0x3C and 0x3A are ignored. This covers the mode field and any commit.
- R9: A commit with a non-zero mode, an offset other than 0 or 1, or offset 1 with data other than 0x3 changes neither the base nor the busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host write enable |
| h_addr | input | 8 | Host word offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr (combinational) |
| rom_rd | output | 1 | ROM read request |
| rom_addr | output | ROM_AW | ROM record address |
| rom_data | input | 32 | ROM record, valid one cycle after rom_rd |
| ch_wr | output | 1 | Channel write request |
| ch_sel | output | CH_W | Target channel |
| ch_addr | output | 16 | Channel register address |
| ch_data | output | 16 | Channel register data |
| ch_ready | input | 1 | Channel accepts the write while ch_wr is high |

## Verification
The bench streams random images of lengths 0, 1 and several, including one whose base sits near the top of the ROM. A design that does not wrap the pointer, that drops or repeats a record under random ch_ready stalls, or that writes the end marker gives a write log that differs from the bench's expected image. Host writes issued mid-stream are checked by reading the registers back after the run and by comparing every ch_sel. A design that let them through would show changed values or a switched channel. Commits with a wrong mode, an unknown offset or a wrong start key are followed by a normal stream, so a base that moved or a spurious start shows up as wrong ROM addresses or an unexpected busy.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
    localparam logic [7:0]  RA_CHAN    = 8'h38;
    localparam logic [7:0]  RA_CTRL    = 8'h3A;
    localparam logic [7:0]  RA_OFFS    = 8'h3B;
    localparam logic [7:0]  RA_DATA    = 8'h3C;
    localparam int          CB_WR      = 0;
    localparam int          CB_MODE    = 2;
    localparam int          CB_BUSY    = 8;
    localparam logic [1:0]  MODE_IMAGE = 2'b00;
    localparam logic [31:0] OFS_BASE   = 32'h0;
    localparam logic [31:0] OFS_START  = 32'h1;
    localparam logic [31:0] START_KEY  = 32'h3;
    localparam logic [15:0] END_ADDR   = 16'hFFFF;

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] data;
    } rec_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_LATCH, SQ_WRITE} sq_state_t;

    function automatic rec_t to_rec(input logic [31:0] w);
        rec_t r;
        r.addr = w[31:16];
        r.data = w[15:0];
        return r;
    endfunction

    function automatic logic is_end(input logic [31:0] w);
        return w[31:16] == END_ADDR;
    endfunction
endpackage

// File: rtl/rcfg_regs.sv
module rcfg_regs
    import rcfg_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int ROM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_en,
    input  logic [7:0]        h_addr,
    input  logic [31:0]       h_wdata,
    input  logic              busy,
    output logic [31:0]       h_rdata,
    output logic [CH_W-1:0]   chan,
    output logic [ROM_AW-1:0] base,
    output logic              start
);
    logic [1:0]  mode;
    logic [31:0] offs;
    logic [31:0] dat;
    logic        ctrl_wr;
    logic        commit;

    assign ctrl_wr = hw_en && !busy && (h_addr == RA_CTRL);
    // the commit uses the mode carried in the same write
    assign commit  = ctrl_wr && h_wdata[CB_WR] &&
                     (h_wdata[CB_MODE+1:CB_MODE] == MODE_IMAGE);
    assign start   = commit && (offs == OFS_START) && (dat == START_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan <= '0;
            mode <= '0;
            offs <= '0;
            dat  <= '0;
            base <= '0;
        end else if (hw_en && !busy) begin
            case (h_addr)
                RA_CHAN: chan <= h_wdata[CH_W-1:0];
                RA_OFFS: offs <= h_wdata;
                RA_DATA: dat  <= h_wdata;
                RA_CTRL: begin
                    mode <= h_wdata[CB_MODE+1:CB_MODE];
                    if (commit && offs == OFS_BASE)
                        base <= dat[ROM_AW-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        h_rdata = '0;
        case (h_addr)
            RA_CHAN: h_rdata[CH_W-1:0] = chan;
            RA_OFFS: h_rdata = offs;
            RA_DATA: h_rdata = dat;
            RA_CTRL: begin
                h_rdata[CB_MODE+1:CB_MODE] = mode;
                h_rdata[CB_BUSY]           = busy;
            end
            default: ;
        endcase
    end

    AST_FROZEN_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy && hw_en |=> $stable(chan) && $stable(offs) && $stable(dat) && $stable(mode) && $stable(base)); // R8
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R4
    AST_BASE_NEEDS_MODE0: assert property (@(posedge clk) disable iff (rst)
        hw_en && h_addr == RA_CTRL && h_wdata[CB_MODE+1:CB_MODE] != MODE_IMAGE |=> $stable(base)); // R9
endmodule

// File: rtl/rcfg_seq.sv
module rcfg_seq
    import rcfg_pkg::*;
#(
    parameter int ROM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROM_AW-1:0] base,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [31:0]       rom_data,
    output logic              ch_wr,
    output logic [15:0]       ch_addr,
    output logic [15:0]       ch_data,
    input  logic              ch_ready,
    output logic              busy
);
    sq_state_t         state;
    logic [ROM_AW-1:0] ptr;
    rec_t              rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            ptr   <= '0;
            rec   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    ptr   <= base;
                    state <= SQ_FETCH;
                end
                SQ_FETCH: state <= SQ_LATCH;
                SQ_LATCH: begin
                    rec   <= to_rec(rom_data);
                    state <= is_end(rom_data) ? SQ_IDLE : SQ_WRITE;
                end
                SQ_WRITE: if (ch_ready) begin
                    ptr   <= ptr + 1'b1;
                    state <= SQ_FETCH;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign rom_rd   = (state == SQ_FETCH);
    assign rom_addr = ptr;
    assign ch_wr    = (state == SQ_WRITE);
    assign ch_addr  = rec.addr;
    assign ch_data  = rec.data;
    assign busy     = (state != SQ_IDLE);

    AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
        ch_wr && !ch_ready |=> ch_wr && $stable(ch_addr) && $stable(ch_data)); // R6
    AST_FETCH_BEFORE_WR: assert property (@(posedge clk) disable iff (rst)
        $rose(ch_wr) |-> $past(rom_rd, 2)); // R5
    AST_NO_RD_DURING_WR: assert property (@(posedge clk) disable iff (rst)
        !(rom_rd && ch_wr)); // R6
    AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(rom_data[31:16] == END_ADDR)); // R7
    AST_NEXT_RECORD: assert property (@(posedge clk) disable iff (rst)
        ch_wr && ch_ready |=> rom_rd && rom_addr == $past(rom_addr) + 1'b1); // R5
endmodule

// File: rtl/rcfg_streamer.sv
module rcfg_streamer
    import rcfg_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int ROM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_en,
    input  logic [7:0]        h_addr,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [31:0]       rom_data,
    output logic              ch_wr,
    output logic [CH_W-1:0]   ch_sel,
    output logic [15:0]       ch_addr,
    output logic [15:0]       ch_data,
    input  logic              ch_ready
);
    logic              busy;
    logic              start;
    logic [ROM_AW-1:0] base;

    rcfg_regs #(.CH_W(CH_W), .ROM_AW(ROM_AW)) u_regs (
        .clk(clk), .rst(rst), .hw_en(hw_en), .h_addr(h_addr),
        .h_wdata(h_wdata), .busy(busy), .h_rdata(h_rdata),
        .chan(ch_sel), .base(base), .start(start)
    );

    rcfg_seq #(.ROM_AW(ROM_AW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .base(base),
        .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
        .ch_wr(ch_wr), .ch_addr(ch_addr), .ch_data(ch_data),
        .ch_ready(ch_ready), .busy(busy)
    );

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !rom_rd && !ch_wr && h_rdata[CB_BUSY] == 1'b0 || h_addr != RA_CTRL); // R1
endmodule

// File: tb/rcfg_streamer_bench.sv
module rcfg_streamer_bench;
    localparam int PERIOD = 10;
    localparam int CH_W   = 4;
    localparam int ROM_AW = 8;
    localparam int DEPTH  = 1 << ROM_AW;

    logic              clk = 1'b0;
    logic              rst;
    logic              hw_en;
    logic [7:0]        h_addr;
    logic [31:0]       h_wdata;
    logic [31:0]       h_rdata;
    logic              rom_rd;
    logic [ROM_AW-1:0] rom_addr;
    logic [31:0]       rom_data;
    logic              ch_wr;
    logic [CH_W-1:0]   ch_sel;
    logic [15:0]       ch_addr;
    logic [15:0]       ch_data;
    logic              ch_ready;

    logic [31:0] rom [DEPTH];
    logic [31:0] log_rec [64];
    logic [CH_W-1:0] log_sel [64];
    int nlog;
    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    rcfg_streamer #(.CH_W(CH_W), .ROM_AW(ROM_AW)) u_rcfg_streamer (
        .clk(clk), .rst(rst), .hw_en(hw_en), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .rom_rd(rom_rd),
        .rom_addr(rom_addr), .rom_data(rom_data), .ch_wr(ch_wr),
        .ch_sel(ch_sel), .ch_addr(ch_addr), .ch_data(ch_data),
        .ch_ready(ch_ready)
    );

    always_ff @(posedge clk) if (rom_rd) rom_data <= rom[rom_addr];

    always @(posedge clk) begin
        if (!rst && ch_wr && ch_ready && nlog < 64) begin
            log_rec[nlog] = {ch_addr, ch_data};
            log_sel[nlog] = ch_sel;
            nlog = nlog + 1;
        end
    end

    always @(negedge clk) ch_ready <= ($urandom % 4) != 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    function automatic logic [31:0] rand_rec();
        logic [15:0] a;
        a = 16'($urandom);
        if (a == 16'hFFFF) a = 16'h0;
        return {a, 16'($urandom)};
    endfunction

    task automatic fill(input int b, input int len);
        for (int i = 0; i < len; i++) rom[(b + i) % DEPTH] = rand_rec();
        rom[(b + len) % DEPTH] = {16'hFFFF, 16'($urandom)};
    endtask

    task automatic launch();
        hwr(8'h3B, 32'h1);
        hwr(8'h3C, 32'h3);
        hwr(8'h3A, 32'h1);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        hrd(8'h3A, v);
        while (v[8] && n < 4000) begin
            @(negedge clk);
            hrd(8'h3A, v);
            n++;
        end
        check(req, {31'b0, v[8]}, 32'h0);
    endtask

    task automatic compare(input string req, input int b, input int len, input logic [CH_W-1:0] c);
        check(req, nlog, len);
        for (int i = 0; i < len && i < nlog; i++) begin
            check(req, log_rec[i], rom[(b + i) % DEPTH]);
            check("R6 ch_sel", {28'b0, log_sel[i]}, {28'b0, c});
        end
    endtask

    task automatic stream(input logic [CH_W-1:0] c, input int b, input int len, input bit poke);
        logic [31:0] v;
        fill(b, len);
        nlog = 0;
        hwr(8'h38, {28'b0, c});
        hwr(8'h3A, 32'h0);
        hwr(8'h3B, 32'h0);
        hwr(8'h3C, b);
        hwr(8'h3A, 32'h1);
        launch();
        hrd(8'h3A, v);
        check("R4 busy after start", {31'b0, v[8]}, 32'h1);
        check("R3 write bit reads 0", {31'b0, v[0]}, 32'h0);
        if (poke && len > 0) begin
            hwr(8'h38, {28'b0, ~c});
            hwr(8'h3B, 32'h0);
            hwr(8'h3C, 32'h55);
            hwr(8'h3A, 32'h9);
        end
        wait_idle("R7 busy clears");
        compare("R5 record", b, len, c);
        if (poke && len > 0) begin
            hrd(8'h38, v); check("R8 chan frozen", v, {28'b0, c});
            hrd(8'h3B, v); check("R8 offs frozen", v, 32'h1);
            hrd(8'h3C, v); check("R8 data frozen", v, 32'h3);
            hrd(8'h3A, v); check("R8 mode frozen", v, 32'h0);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) rom[i] = 32'h0;
        hw_en = 1'b0; h_addr = 8'h0; h_wdata = 32'h0; nlog = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        hrd(8'h38, v); check("R1 chan", v, 0);
        hrd(8'h3A, v); check("R1 ctrl", v, 0);
        hrd(8'h3B, v); check("R1 offs", v, 0);
        hrd(8'h3C, v); check("R1 data", v, 0);
        check("R1 strobes", {30'b0, rom_rd, ch_wr}, 0);

        hwr(8'h38, 32'h5); hrd(8'h38, v); check("R2 chan", v, 32'h5);
        hwr(8'h3B, 32'hA5A5_0F0F); hrd(8'h3B, v); check("R2 offs", v, 32'hA5A5_0F0F);
        hwr(8'h3C, 32'h1234_5678); hrd(8'h3C, v); check("R2 data", v, 32'h1234_5678);
        hwr(8'h3A, 32'h8); hrd(8'h3A, v); check("R2 mode", v, 32'h8);
        hwr(8'h40, 32'hFFFF_FFFF); hrd(8'h40, v); check("R2 unmapped", v, 0);
        hwr(8'h3B, 32'h7); hwr(8'h3C, 32'h3); hwr(8'h3A, 32'h1);
        hrd(8'h3A, v); check("R3 commit bit self-clears", v, 0);
        check("R9 unknown offset", {31'b0, v[8]}, 0);

        stream(4'h0, 8'h00 + 8'h80, 0, 1'b0);
        stream(4'h3, 8'h10, 1, 1'b0);
        stream(4'h7, 8'h20, 5, 1'b1);
        stream(4'h9, 8'hFD, 6, 1'b0);
        for (int k = 0; k < 6; k++)
            stream(4'($urandom), int'(8'($urandom)), 3 + int'($urandom % 10), k[0]);

        // R9: a base commit with mode 1 must not move the base, bad starts do nothing
        nlog = 0;
        fill(8'h30, 3);
        rom[8'h60] = {16'hFFFF, 16'h0};
        hwr(8'h3A, 32'h0);
        hwr(8'h3B, 32'h0); hwr(8'h3C, 32'h30); hwr(8'h3A, 32'h1);
        hwr(8'h3C, 32'h60); hwr(8'h3A, 32'h5);
        hwr(8'h3B, 32'h1); hwr(8'h3C, 32'h3); hwr(8'h3A, 32'h5);
        hrd(8'h3A, v); check("R9 start with mode 1", {31'b0, v[8]}, 0);
        hwr(8'h3C, 32'h2); hwr(8'h3A, 32'h1);
        hrd(8'h3A, v); check("R9 wrong key", {31'b0, v[8]}, 0);
        check("R9 no writes", nlog, 0);
        launch();
        wait_idle("R9 busy clears");
        compare("R9 base kept", 8'h30, 3, 4'($urandom) & 4'h0 | ch_sel);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule